// File: doc/BRIEF.md
# Refill Victim Way Selector

This block decides which way of a set-associative cache takes a new line on a refill. The cache controller gives it the per-way valid bits read from the tag store for the addressed set, and strobes a capture enable while it is idle so that those bits are held in a local register. While the controller waits for refill data, it raises a fill-wait strobe. On each clock edge with that strobe high, the block registers a one-hot way select and advances its pseudo-random source.

An empty way always wins, and the lowest-numbered empty way is taken first. When every way of the set holds a line, a 4-bit linear feedback shift register picks the victim. Its three upper bits index a fixed mapping table, and the table depends on the way count. The way count is 2, 3, 4 or 8 and is chosen by a parameter. Any other count stops elaboration. A synchronous flush input clears the captured valid vector, so the next refill goes to way 0.

Top module: `victim_way_pick`

## Requirements
- R1: After a synchronous active-low reset, `way_sel` selects way 0 (value 1), the LFSR holds 4'hF and the captured valid vector is all zero.
- R2: On a clock edge with `capture_en` high and `flush` low, the captured valid vector loads `way_valid`. With both low, the vector keeps its value even if `way_valid` changes.
- R3: On a clock edge with `flush` high, the captured valid vector clears to zero, whatever `capture_en` is. A following refill therefore selects way 0.
- R4: If any captured valid bit is 0, the refill selects the lowest-numbered way whose bit is 0. A way whose bit is 1 is never chosen while an invalid way exists.
- R5: `way_sel` and the LFSR change only on edges with `fill_wait` high. On such an edge, `way_sel` takes the choice made from the current LFSR value. The LFSR then shifts left, and its new bit 0 is old bit 3 XOR old bit 2. Starting from F, the sequence runs F, E, C, 8, 1, 2, 4, 9, 3, 6, D, A, 5, B, 7.
- R6: With all ways valid, let r be LFSR bits [3:1]. The chosen way depends on the way count:
  - 2 ways: way 1 for r = 0, 3, 5 or 6, and way 0 otherwise.
  - 3 ways: way 1 for r = 0 to 2, way 2 for r = 3 or 4, and way 0 for r = 5 to 7.
  - 4 ways: way 2 for r = 0 or 1, way 3 for r = 2 or 3, way 0 for r = 4 or 5, and way 1 for r = 6 or 7.
  - 8 ways: way (r+4) mod 8.
- R7: `way_sel` has exactly one bit set in every cycle out of reset. Way counts other than 2, 3, 4 and 8 are rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| capture_en | input | 1 | Controller idle: load the valid vector |
| way_valid | input | NWAYS | Per-way valid bits of the addressed set |
| fill_wait | input | 1 | Controller waiting for refill: register the choice and step the LFSR |
| flush | input | 1 | Synchronous clear of the captured valid vector |
| way_sel | output | NWAYS | Registered one-hot way for the refill |

## Verification
The assertions assume that `capture_en` and `fill_wait` are never high together, because a real controller is either idle or waiting for a fill. They also assume that `way_valid` is meaningful only on capture edges. The stimulus keeps to this by pulsing capture in one cycle and fill-wait in a separate later cycle, and by changing `way_valid` freely only while capture is low. The no-skip property compares each new selection with the valid vector captured before that fill edge. This holds only because the vector cannot change on the fill edge itself.

// File: rtl/wp_pkg.sv
// Shared definitions for the victim way selector.
// Assumes a 4-bit maximal-length LFSR; widths below derive from it.
package wp_pkg;

    localparam int RND_W  = 4;
    localparam int IDX3_W = 3;
    localparam logic [RND_W-1:0] RND_SEED = 4'hF;

    // One LFSR step: shift left, feed back bit3 ^ bit2 into bit 0.
    function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] cur);
        return {cur[RND_W-2:0], cur[RND_W-1] ^ cur[RND_W-2]};
    endfunction

    // Way counts the selector supports.
    function automatic bit ways_legal(input int n);
        return (n == 2) || (n == 3) || (n == 4) || (n == 8);
    endfunction

endpackage

// File: rtl/wp_rnd_gen.sv
// Pseudo-random source for victim choice.
// Holds a 4-bit LFSR that steps only when step_en is high.
// Assumes a synchronous active-low reset that loads the seed.
module wp_rnd_gen
    import wp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    output logic [RND_W-1:0] rnd
);

    // Advance the LFSR once per fill-wait cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rnd <= RND_SEED;
        else if (step_en)
            rnd <= rnd_step(rnd);
    end

    // R5: the LFSR is frozen outside fill-wait.
    p_rnd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(rnd));

    // R5: the all-zero lock-up state is never reached.
    p_rnd_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rnd != '0);

endmodule

// File: rtl/wp_valid_hold.sv
// Captured per-way valid vector for the set being refilled.
// Loads while the controller is idle and clears on flush.
// Assumes flush takes priority over capture.
module wp_valid_hold #(
    parameter int NWAYS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_en,
    input  logic             flush,
    input  logic [NWAYS-1:0] way_valid,
    output logic [NWAYS-1:0] valid_q
);

    // Capture the tag valid bits; hold them through a refill.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)
            valid_q <= '0;
        else if (capture_en)
            valid_q <= way_valid;
    end

    // R3: a flush leaves the vector empty.
    p_flush_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> valid_q == '0);

    // R2: without capture or flush the vector is held.
    p_valid_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !capture_en) |=> $stable(valid_q));

endmodule

// File: rtl/wp_victim_map.sv
// Combinational victim choice.
// Picks the lowest invalid way. When the set is full, it maps the
// three upper LFSR bits through a table chosen by the way count.
// Assumes NWAYS is 2, 3, 4 or 8; the top rejects other counts.
module wp_victim_map
    import wp_pkg::*;
#(
    parameter int NWAYS = 4
) (
    input  logic [NWAYS-1:0] valid_vec,
    input  logic [RND_W-1:0] rnd,
    output logic [NWAYS-1:0] pick
);

    localparam int IDX_W = (NWAYS > 1) ? $clog2(NWAYS) : 1;

    logic [IDX3_W-1:0] r;
    logic [IDX_W-1:0]  full_idx;
    logic [NWAYS-1:0]  full_pick;

    assign r = rnd[RND_W-1:1];

    generate
        if (NWAYS == 2) begin : g_tab2
            // Table for two ways.
            always_comb begin
                case (r)
                    3'd0, 3'd3, 3'd5, 3'd6: full_idx = 1'b1;
                    default:                full_idx = 1'b0;
                endcase
            end
        end else if (NWAYS == 3) begin : g_tab3
            // Table for three ways.
            always_comb begin
                case (r)
                    3'd0, 3'd1, 3'd2: full_idx = 2'd1;
                    3'd3, 3'd4:       full_idx = 2'd2;
                    default:          full_idx = 2'd0;
                endcase
            end
        end else if (NWAYS == 4) begin : g_tab4
            // Table for four ways: pairs of r rotate through ways 2,3,0,1.
            always_comb full_idx = r[2:1] + 2'd2;
        end else begin : g_tab8
            // Table for eight ways: upper half first, then lower half.
            always_comb full_idx = IDX_W'(r + 3'd4);
        end
    endgenerate

    // Expand the full-set index into one-hot form.
    always_comb full_pick = NWAYS'(1) << full_idx;

    // Lowest empty way wins; otherwise use the table.
    always_comb begin
        pick = full_pick;
        for (int w = NWAYS - 1; w >= 0; w--) begin
            if (!valid_vec[w])
                pick = NWAYS'(1) << w;
        end
    end

    // R7: the choice is always one-hot.
    always_comb begin
        a_pick_onehot_r7: assert ($countones(pick) == 1 || $isunknown(valid_vec) || $isunknown(rnd));
    end

endmodule

// File: rtl/victim_way_pick.sv
// Refill victim way selector (top).
// Registers the captured valid vector, steps an LFSR during fill-wait,
// and registers a one-hot way choice on each fill-wait edge.
// Assumes capture_en and fill_wait are not high in the same cycle.
module victim_way_pick
    import wp_pkg::*;
#(
    parameter int NWAYS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_en,
    input  logic [NWAYS-1:0] way_valid,
    input  logic             fill_wait,
    input  logic             flush,
    output logic [NWAYS-1:0] way_sel
);

    localparam logic [NWAYS-1:0] WAY0 = NWAYS'(1);

    generate
        if (!ways_legal(NWAYS)) begin : g_bad_ways
            $error("victim_way_pick: NWAYS must be 2, 3, 4 or 8");
        end
    endgenerate

    logic [NWAYS-1:0] valid_q;
    logic [RND_W-1:0] rnd;
    logic [NWAYS-1:0] pick;

    wp_valid_hold #(.NWAYS(NWAYS)) u_valid (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_en (capture_en),
        .flush      (flush),
        .way_valid  (way_valid),
        .valid_q    (valid_q)
    );

    wp_rnd_gen u_rnd (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (fill_wait),
        .rnd     (rnd)
    );

    wp_victim_map #(.NWAYS(NWAYS)) u_map (
        .valid_vec (valid_q),
        .rnd       (rnd),
        .pick      (pick)
    );

    // Register the chosen way during fill-wait.
    always_ff @(posedge clk) begin
        if (!rst_n)
            way_sel <= WAY0;
        else if (fill_wait)
            way_sel <= pick;
    end

    // R7: exactly one way is selected in every cycle.
    p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(way_sel) == 1);

    // R5: the selection moves only on fill-wait edges.
    p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_wait |=> $stable(way_sel));

    // R4: with an empty way present, a filled way is never chosen.
    p_no_skip_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_wait && !(&valid_q)) |=> (way_sel & $past(valid_q)) == '0);

    // R3: a refill right after a flush targets way 0.
    p_flush_way0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !capture_en) |=> (fill_wait |=> way_sel == WAY0));

endmodule

// File: tb/sim_victim_way_pick.sv
`timescale 1ns/1ps
module sim_victim_way_pick;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       capture_en = 1'b0;
    logic       fill_wait = 1'b0;
    logic       flush = 1'b0;
    logic [3:0] v4 = '0;
    logic [1:0] v2 = '0;
    logic [2:0] v3 = '0;
    logic [7:0] v8 = '0;
    logic [3:0] s4;
    logic [1:0] s2;
    logic [2:0] s3;
    logic [7:0] s8;

    int total = 0;
    int bad = 0;
    logic [3:0] m = 4'hF;   // bench model of the LFSR

    always #2 clk = ~clk;   // 250 MHz

    victim_way_pick #(.NWAYS(4)) u0 (.clk(clk), .rst_n(rst_n), .capture_en(capture_en),
        .way_valid(v4), .fill_wait(fill_wait), .flush(flush), .way_sel(s4));
    victim_way_pick #(.NWAYS(2)) u_w2 (.clk(clk), .rst_n(rst_n), .capture_en(capture_en),
        .way_valid(v2), .fill_wait(fill_wait), .flush(flush), .way_sel(s2));
    victim_way_pick #(.NWAYS(3)) u_w3 (.clk(clk), .rst_n(rst_n), .capture_en(capture_en),
        .way_valid(v3), .fill_wait(fill_wait), .flush(flush), .way_sel(s3));
    victim_way_pick #(.NWAYS(8)) u_w8 (.clk(clk), .rst_n(rst_n), .capture_en(capture_en),
        .way_valid(v8), .fill_wait(fill_wait), .flush(flush), .way_sel(s8));

    // {valid[3:0], expected one-hot[3:0]} for the 4-way unit; 0 = use table model
    localparam logic [7:0] VEC [11] = '{
        8'b0000_0001, 8'b0001_0010, 8'b0011_0100, 8'b0111_1000,
        8'b1110_0001, 8'b1101_0010, 8'b1011_0100, 8'b0110_0001,
        8'b1010_0001, 8'b0101_0010, 8'b1111_0000 };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b", req, act, exp);
        end
    endtask

    // Expected choice from the requirements (R4 then R6).
    function automatic logic [7:0] exp_pick(input int nw, input logic [7:0] v, input logic [3:0] lf);
        logic [2:0] r;
        int idx;
        r = lf[3:1];
        for (int w = 0; w < nw; w++)
            if (!v[w]) return 8'(1) << w;
        case (nw)
            2: idx = (r == 0 || r == 3 || r == 5 || r == 6) ? 1 : 0;
            3: idx = (r <= 2) ? 1 : (r <= 4) ? 2 : 0;
            4: idx = (r <= 1) ? 2 : (r <= 3) ? 3 : (r <= 5) ? 0 : 1;
            default: idx = (int'(r) + 4) % 8;
        endcase
        return 8'(1) << idx;
    endfunction

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic load(input logic [7:0] v);
        v8 = v; v4 = v[3:0]; v3 = v[2:0]; v2 = v[1:0];
    endtask

    // One fill-wait cycle, then check all units against the model.
    task automatic fill_check(input string req, input logic [7:0] v, input logic [7:0] exp4);
        logic [7:0] e4;
        fill_wait = 1'b1;
        cyc();
        fill_wait = 1'b0;
        e4 = (exp4 != 0) ? exp4 : exp_pick(4, {4'hF, v[3:0]}, m);
        check(req, {4'b0, s4}, e4);
        check(req, {6'b0, s2}, exp_pick(2, {6'h3F, v[1:0]}, m));
        check(req, {5'b0, s3}, exp_pick(3, {5'h1F, v[2:0]}, m));
        check(req, s8, exp_pick(8, v, m));
        m = {m[2:0], m[3] ^ m[2]};
    endtask

    task automatic cap(input logic [7:0] v);
        load(v);
        capture_en = 1'b1;
        cyc();
        capture_en = 1'b0;
    endtask

    // R7: one-hot output monitor, sampled away from the edge.
    always @(negedge clk) begin
        if (rst_n && !$isunknown(s4)) begin
            total++;
            if ($countones(s4) != 1 || $countones(s8) != 1) begin
                bad++;
                $display("FAIL R7 act=%b/%b exp=one-hot", s4, s8);
            end
        end
    end

    initial begin
        #(4 * 100000);
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(); cyc();
        rst_n = 1'b1;
        // R1: reset state is way 0 on every unit
        check("R1", {4'b0, s4}, 8'h01);
        check("R1", s8, 8'h01);
        // R1: first fill with valid vector cleared by reset -> way 0
        fill_check("R1", 8'h00, 8'h01);

        // Vector walk: R4 priority and R6 full-set table
        foreach (VEC[i]) begin
            cap({4'hF, VEC[i][7:4]});
            fill_check((VEC[i][7:4] == 4'hF) ? "R6" : "R4", {4'hF, VEC[i][7:4]}, {4'b0, VEC[i][3:0]});
        end

        // R5/R6: full sets through a whole LFSR period
        cap(8'hFF);
        for (int k = 0; k < 16; k++) begin
            fill_check("R5", 8'hFF, 8'h00);
            cyc();
        end

        // R5: selection holds without fill-wait
        begin
            logic [3:0] keep;
            keep = s4;
            load(8'h00);
            cyc(); cyc(); cyc();
            check("R5", {4'b0, s4}, {4'b0, keep});
        end

        // R2: vector held when capture is low, even as way_valid changes
        cap(8'hF3);
        load(8'h00);
        cyc();
        fill_check("R2", 8'hF3, 8'h04);

        // R3: flush wins over capture; next fill takes way 0
        cap(8'hFF);
        load(8'hFF);
        flush = 1'b1; capture_en = 1'b1;
        cyc();
        flush = 1'b0; capture_en = 1'b0;
        fill_check("R3", 8'h00, 8'h01);

        // R4: sparse 8-way case, lowest empty way is way 5
        cap(8'hDF);
        fill_check("R4", 8'hDF, 8'h00);

        cyc();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule